// File: doc/BRIEF.md
# Packed-Write RGB Palette Loader

This block holds a colour lookup table and fills it from a 32-bit host write stream. Software first writes a starting entry number into the pointer register. It then pushes colour bytes through a data register. Each entry takes three bytes in a fixed red, green, blue order. An internal component sequencer stores the bytes and advances the entry pointer on its own after each blue byte. In packed mode a single bus word carries four colour bytes, so an entry may be split across two words. In narrow mode each word carries one byte, in its top lane.

A second small palette of four entries, meant for overlay or cursor colours, is loaded in the same way through its own data register. It has its own sequencer, and its pointer is taken from the low bits of the same pointer write. The pixel side has two lookup ports, one per palette. Each presents an index and receives the stored colour one clock later.

The host side is a write-only valid/ready channel. A word is taken on a clock edge where `host_valid` and `host_ready` are both high. The block drops `host_ready` while it is still splitting an earlier data word into bytes. While `host_ready` is low, the host holds its word and its address.

Top module: `palette_loader`

## Requirements
- R1: After reset, every main and overlay entry reads 0, both pointers are 0, the next byte is red, and `host_ready` is high.
- R2: An accepted write at offset 0 loads the main pointer from `host_wdata[ENTRY_BITS-1:0]` and the overlay pointer from `host_wdata[OVL_BITS-1:0]`. It also makes red the next component for both palettes, discarding any partly received entry.
- R3: Bytes are taken in the order red, green, blue. The entry is written as {red[23:16], green[15:8], blue[7:0]} on the cycle its blue byte is processed, and a partly received entry leaves the table unchanged.
- R4: After each blue byte the pointer of that palette steps by one, wrapping from its last entry to 0.
- R5: With `narrow_mode` low, a data word supplies four bytes, taken from bits 31:24 down to bits 7:0. The component order continues across word boundaries.
- R6: With `narrow_mode` high, a data word supplies only bits 31:24 as one byte, and bits 23:0 have no effect.
- R7: After a data word is accepted, `host_ready` stays low for 4 cycles in packed mode and for 1 cycle in narrow mode. Writes at offsets 0 and 2 leave `host_ready` high.
- R8: A write at offset 2 is accepted and has no effect on either palette, on either pointer, or on the component order.
- R9: Offset 1 carries main-palette bytes and offset 3 carries overlay bytes. The overlay has 2^OVL_BITS entries and its own pointer and component order, and it never writes the main palette.
- R10: A lookup returns the entry addressed by the index on the previous clock edge. If that entry is written on the same edge, the lookup returns its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| narrow_mode | input | 1 | 1: one byte per data word (top lane); 0: four bytes per word |
| host_valid | input | 1 | Host write word is present |
| host_ready | output | 1 | Block accepts a word this cycle |
| host_addr | input | 2 | Word offset: 0 pointer, 1 main data, 2 control, 3 overlay data |
| host_wdata | input | 32 | Host write word |
| pix_idx | input | ENTRY_BITS | Main palette lookup index |
| pix_color | output | 24 | Main palette colour, one clock after index |
| ovl_idx | input | OVL_BITS | Overlay palette lookup index |
| ovl_color | output | 24 | Overlay colour, one clock after index |

## Verification
The bench builds the block with ENTRY_BITS=4 and OVL_BITS=2, so the main table holds 16 entries and the overlay holds 4. At that size every entry can be read back after every load. A packed sweep is started from each of the 16 pointer values, which covers every alignment of entries against word boundaries and every wrap of the pointer. Narrow loads, restarts in the middle of an entry, control writes, overlay loads and a lookup that lands on the same edge as a write are each checked against a table computed from an arithmetic byte pattern.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int BYTE_W  = 8;
  localparam int LANES   = 4;
  localparam int WORD_W  = BYTE_W * LANES;
  localparam int COLOR_W = 3 * BYTE_W;

  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;

  typedef enum logic [1:0] {
    OFS_PTR  = 2'd0,
    OFS_MAIN = 2'd1,
    OFS_CTRL = 2'd2,
    OFS_OVL  = 2'd3
  } ofs_e;

  typedef struct packed {
    logic              vld;
    logic              ovl;
    logic [BYTE_W-1:0] val;
  } beat_t;
endpackage

// File: rtl/pal_unpack.sv
module pal_unpack
  import pal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_ovl,
  input  logic              load_narrow,
  input  logic [WORD_W-1:0] word,
  output beat_t             beat,
  output logic              busy
);
  localparam int CNT_W = $clog2(LANES + 1);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  left_q;
  logic              ovl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
      ovl_q   <= 1'b0;
    end else if (load) begin
      shreg_q <= word;
      left_q  <= load_narrow ? CNT_W'(1) : CNT_W'(LANES);
      ovl_q   <= load_ovl;
    end else if (left_q != '0) begin
      shreg_q <= shreg_q << BYTE_W;
      left_q  <= left_q - CNT_W'(1);
    end
  end

  assign busy     = (left_q != '0);
  assign beat.vld = busy;
  assign beat.ovl = ovl_q;
  assign beat.val = shreg_q[WORD_W-1 -: BYTE_W];
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [IDX_W-1:0]   start_idx,
  input  logic               byte_vld,
  input  logic [BYTE_W-1:0]  byte_val,
  output logic               we,
  output logic [IDX_W-1:0]   waddr,
  output logic [COLOR_W-1:0] wdata,
  output logic [IDX_W-1:0]   ptr
);
  comp_e             comp_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] red_q, grn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comp_q <= COMP_R;
      ptr_q  <= '0;
      red_q  <= '0;
      grn_q  <= '0;
    end else if (restart) begin
      comp_q <= COMP_R;
      ptr_q  <= start_idx;
    end else if (byte_vld) begin
      unique case (comp_q)
        COMP_R: begin
          red_q  <= byte_val;
          comp_q <= COMP_G;
        end
        COMP_G: begin
          grn_q  <= byte_val;
          comp_q <= COMP_B;
        end
        default: begin
          ptr_q  <= ptr_q + IDX_W'(1);
          comp_q <= COMP_R;
        end
      endcase
    end
  end

  assign we    = byte_vld && !restart && (comp_q == COMP_B);
  assign waddr = ptr_q;
  assign wdata = {red_q, grn_q, byte_val};
  assign ptr   = ptr_q;
endmodule

// File: rtl/pal_ram.sv
module pal_ram
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [COLOR_W-1:0] wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [COLOR_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COLOR_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/palette_loader.sv
module palette_loader
  import pal_pkg::*;
#(
  parameter int ENTRY_BITS = 8,
  parameter int OVL_BITS   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  narrow_mode,
  input  logic                  host_valid,
  output logic                  host_ready,
  input  logic [1:0]            host_addr,
  input  logic [31:0]           host_wdata,
  input  logic [ENTRY_BITS-1:0] pix_idx,
  output logic [23:0]           pix_color,
  input  logic [OVL_BITS-1:0]   ovl_idx,
  output logic [23:0]           ovl_color
);
  logic  accept, ptr_load, data_load, busy;
  beat_t beat;

  logic                  main_we, ovl_we;
  logic [ENTRY_BITS-1:0] main_waddr, main_ptr;
  logic [OVL_BITS-1:0]   ovl_waddr, ovl_ptr;
  logic [COLOR_W-1:0]    main_wdata, ovl_wdata;

  assign host_ready = !busy;
  assign accept     = host_valid && host_ready;
  assign ptr_load   = accept && (host_addr == OFS_PTR);
  assign data_load  = accept && ((host_addr == OFS_MAIN) || (host_addr == OFS_OVL));

  pal_unpack unpack_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (data_load),
    .load_ovl   (host_addr == OFS_OVL),
    .load_narrow(narrow_mode),
    .word       (host_wdata),
    .beat       (beat),
    .busy       (busy)
  );

  pal_seq #(.IDX_W(ENTRY_BITS)) main_seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ptr_load),
    .start_idx(host_wdata[ENTRY_BITS-1:0]),
    .byte_vld (beat.vld && !beat.ovl),
    .byte_val (beat.val),
    .we       (main_we),
    .waddr    (main_waddr),
    .wdata    (main_wdata),
    .ptr      (main_ptr)
  );

  pal_seq #(.IDX_W(OVL_BITS)) ovl_seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ptr_load),
    .start_idx(host_wdata[OVL_BITS-1:0]),
    .byte_vld (beat.vld && beat.ovl),
    .byte_val (beat.val),
    .we       (ovl_we),
    .waddr    (ovl_waddr),
    .wdata    (ovl_wdata),
    .ptr      (ovl_ptr)
  );

  pal_ram #(.IDX_W(ENTRY_BITS)) main_ram_i (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (main_we),
    .waddr(main_waddr),
    .wdata(main_wdata),
    .raddr(pix_idx),
    .rdata(pix_color)
  );

  pal_ram #(.IDX_W(OVL_BITS)) ovl_ram_i (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (ovl_we),
    .waddr(ovl_waddr),
    .wdata(ovl_wdata),
    .raddr(ovl_idx),
    .rdata(ovl_color)
  );
endmodule

// File: rtl/palette_loader_chk.sv
module palette_loader_chk #(
  parameter int ENTRY_BITS = 8,
  parameter int OVL_BITS   = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  host_valid,
  input logic                  host_ready,
  input logic [1:0]            host_addr,
  input logic [31:0]           host_wdata,
  input logic                  main_we,
  input logic                  ovl_we,
  input logic [ENTRY_BITS-1:0] main_ptr,
  input logic [OVL_BITS-1:0]   ovl_ptr
);
  logic       acc;
  logic [3:0] stall_cnt;

  assign acc = host_valid && host_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)          stall_cnt <= '0;
    else if (host_ready) stall_cnt <= '0;
    else                 stall_cnt <= stall_cnt + 4'd1;
  end

  // R7
  data_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && host_addr[0] |=> !host_ready);

  // R7
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= 4'd4);

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (host_addr == 2'd0) |=>
      (main_ptr == $past(host_wdata[ENTRY_BITS-1:0])) &&
      (ovl_ptr == $past(host_wdata[OVL_BITS-1:0])));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_we |=> main_ptr == ENTRY_BITS'($past(main_ptr) + 1'b1));

  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_we && ovl_we));

  // R8
  ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (host_addr == 2'd2) |=> host_ready && !main_we && !ovl_we);
endmodule

bind palette_loader palette_loader_chk #(
  .ENTRY_BITS(ENTRY_BITS),
  .OVL_BITS  (OVL_BITS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_valid(host_valid),
  .host_ready(host_ready),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .main_we   (main_we),
  .ovl_we    (ovl_we),
  .main_ptr  (main_ptr),
  .ovl_ptr   (ovl_ptr)
);

// File: tb/palette_loader_tb_top.sv
module palette_loader_tb_top;
  localparam int EB = 4;
  localparam int OB = 2;
  localparam int NM = 1 << EB;
  localparam int NO = 1 << OB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          narrow_mode = 1'b0;
  logic          host_valid = 1'b0;
  logic          host_ready;
  logic [1:0]    host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic [EB-1:0] pix_idx = '0;
  logic [23:0]   pix_color;
  logic [OB-1:0] ovl_idx = '0;
  logic [23:0]   ovl_color;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [23:0] exp_main [NM];
  logic [23:0] exp_ovl  [NO];

  always #5 clk = ~clk;

  palette_loader #(.ENTRY_BITS(EB), .OVL_BITS(OB)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .narrow_mode(narrow_mode),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .pix_idx    (pix_idx),
    .pix_color  (pix_color),
    .ovl_idx    (ovl_idx),
    .ovl_color  (ovl_color)
  );

  function automatic logic [7:0] bv(int j, int seed);
    return 8'((j * 37 + seed * 11 + 5) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns number of cycles host_ready stayed low after the accepted word
  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int stall);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1'b1;
    host_addr  = a;
    host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0;
    stall = 0;
    while (!host_ready) begin
      stall++;
      @(negedge clk);
    end
  endtask

  task automatic look_main(input int idx, output logic [23:0] c);
    @(negedge clk);
    pix_idx = EB'(idx);
    @(negedge clk);
    c = pix_color;
  endtask

  task automatic look_ovl(input int idx, output logic [23:0] c);
    @(negedge clk);
    ovl_idx = OB'(idx);
    @(negedge clk);
    c = ovl_color;
  endtask

  task automatic check_all(string req);
    logic [23:0] c;
    for (int i = 0; i < NM; i++) begin
      look_main(i, c);
      check(req, {8'h0, c}, {8'h0, exp_main[i]});
    end
    for (int i = 0; i < NO; i++) begin
      look_ovl(i, c);
      check(req, {8'h0, c}, {8'h0, exp_ovl[i]});
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int st;
    logic [23:0] c;
    for (int i = 0; i < NM; i++) exp_main[i] = '0;
    for (int i = 0; i < NO; i++) exp_ovl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 ready", {31'h0, host_ready}, 32'h1);
    check_all("R1");

    // R5 R4 R3: packed sweep from every start pointer, wraps through all entries
    narrow_mode = 1'b0;
    for (int s = 0; s < NM; s++) begin
      wr(2'd0, 32'(s), st);
      check("R7 ptr-no-stall", 32'(st), 32'h0);
      for (int w = 0; w < 12; w++) begin
        wr(2'd1, {bv(4*w, s), bv(4*w+1, s), bv(4*w+2, s), bv(4*w+3, s)}, st);
        check("R7 packed-stall", 32'(st), 32'h4);
      end
      for (int n = 0; n < NM; n++)
        exp_main[(s + n) % NM] = {bv(3*n, s), bv(3*n+1, s), bv(3*n+2, s)};
      check_all("R5 R4 R3 sweep");
    end

    // R6 narrow: only top byte counts
    narrow_mode = 1'b1;
    wr(2'd0, 32'h2, st);
    for (int j = 0; j < 9; j++) begin
      wr(2'd1, {bv(j, 40), 24'(32'hA5C37E ^ j)}, st);
      check("R7 narrow-stall", 32'(st), 32'h1);
    end
    for (int n = 0; n < 3; n++) exp_main[2 + n] = {bv(3*n, 40), bv(3*n+1, 40), bv(3*n+2, 40)};
    check_all("R6");

    // R3 R2 partial entry, then restart mid-entry
    narrow_mode = 1'b0;
    wr(2'd0, 32'h7, st);
    wr(2'd1, {bv(0, 50), bv(1, 50), bv(2, 50), bv(3, 50)}, st);
    exp_main[7] = {bv(0, 50), bv(1, 50), bv(2, 50)};
    check_all("R3 partial");
    narrow_mode = 1'b1;
    wr(2'd0, 32'h9, st);
    wr(2'd1, {bv(4, 50), 24'h0}, st);
    wr(2'd1, {bv(5, 50), 24'h0}, st);
    // R10: index 9 presented before the blue write edge
    @(negedge clk);
    pix_idx = EB'(9);
    @(negedge clk);
    host_valid = 1'b1;
    host_addr  = 2'd1;
    host_wdata = {bv(6, 50), 24'hFFFFFF};
    @(negedge clk);
    host_valid = 1'b0;
    @(negedge clk);
    check("R10 same-edge old", {8'h0, pix_color}, {8'h0, exp_main[9]});
    @(negedge clk);
    exp_main[9] = {bv(4, 50), bv(5, 50), bv(6, 50)};
    check("R10 next new", {8'h0, pix_color}, {8'h0, exp_main[9]});
    check_all("R2 restart");

    // R8 control write ignored, sequence intact
    wr(2'd0, 32'h0, st);
    wr(2'd1, {bv(0, 60), 24'h0}, st);
    wr(2'd2, 32'hFFFFFFFF, st);
    check("R8 ctrl-no-stall", 32'(st), 32'h0);
    check_all("R8 unchanged");
    wr(2'd1, {bv(1, 60), 24'h0}, st);
    wr(2'd1, {bv(2, 60), 24'h0}, st);
    exp_main[0] = {bv(0, 60), bv(1, 60), bv(2, 60)};
    check_all("R8 order kept");

    // R9 overlay packed load from pointer low bits, wrapping
    narrow_mode = 1'b0;
    wr(2'd0, 32'h7, st);
    for (int w = 0; w < 3; w++) begin
      wr(2'd3, {bv(4*w, 70), bv(4*w+1, 70), bv(4*w+2, 70), bv(4*w+3, 70)}, st);
      check("R9 ovl-stall", 32'(st), 32'h4);
    end
    for (int n = 0; n < NO; n++) exp_ovl[(3 + n) % NO] = {bv(3*n, 70), bv(3*n+1, 70), bv(3*n+2, 70)};
    check_all("R9");

    // R9 overlay narrow
    narrow_mode = 1'b1;
    wr(2'd0, 32'h1, st);
    for (int j = 0; j < 3; j++) wr(2'd3, {bv(j, 80), 24'h123456}, st);
    exp_ovl[1] = {bv(0, 80), bv(1, 80), bv(2, 80)};
    check_all("R9 R6 ovl");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule